// File: doc/BRIEF.md
# Filtered Edge Input Capture Channel

This block timestamps events on one external input. The input is asynchronous to the block clock. It passes through a synchroniser and then a level filter with a programmable sample count. After the filter, an edge detector picks rising or falling transitions and an event divider keeps every 1st, 2nd, 4th or 8th of them. On each event that gets through, the block copies the time-base count into a capture register. The time-base count is supplied from outside on a bus.

Each capture raises a capture flag. Software clears that flag by reading the capture register, which is signalled to the block by a one-cycle read strobe. If a new capture lands while the flag is still set, an overcapture flag records that a value was lost. The capture flag, gated by an interrupt enable, drives an interrupt request. A channel enable gates every capture.

Top module: `capture_channel`

## Requirements
- R1: After a synchronous active-low reset, `cap_value` is 0 and `cap_flag`, `ovr_flag` and `irq` are 0.
- R2: With `edge_sel`=0, a rising transition on `pin_in` that survives the filter is captured. Let edge k be the first clock edge that samples the new pin level, and let N be the filter sample count. `cap_value` takes the `count_in` value present at edge k+2+N.
- R3: With `edge_sel`=1, falling transitions are captured with the same latency as in R2, and rising transitions cause no capture.
- R4: `filt_sel` codes 0, 1, 2 and 3 give N = 1, 2, 4 and 8 samples. The filtered level changes only after N consecutive samples differ from it. A pulse held for fewer than N cycles therefore causes no capture, and one held for N cycles is accepted.
- R5: `psc_sel` codes 0, 1, 2 and 3 give division by 1, 2, 4 and 8. A capture happens on every D-th qualifying edge, counted from enable or from the previous capture.
- R6: While `chan_en` is 0, no capture occurs and the event divider count is cleared. After re-enabling, a full D edges are needed before the next capture.
- R7: `cap_flag` is set in the cycle after a capture. It is cleared in the cycle after a `rd_strobe` pulse, unless a capture happens in that same cycle, in which case the capture wins.
- R8: A capture that arrives while `cap_flag` is set, with no `rd_strobe` in that cycle, sets `ovr_flag`. The new value overwrites `cap_value`. `ovr_clr` clears `ovr_flag`.
- R9: `irq` is high exactly when `cap_flag` and `irq_en` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_en | input | 1 | Channel enable; gates captures and clears the divider |
| edge_sel | input | 1 | 0 = rising edges, 1 = falling edges |
| filt_sel | input | 2 | Filter sample count code (1/2/4/8 samples) |
| psc_sel | input | 2 | Event divider code (1/2/4/8) |
| irq_en | input | 1 | Interrupt enable |
| pin_in | input | 1 | Asynchronous channel input |
| count_in | input | CNT_W | Time-base count to be captured |
| rd_strobe | input | 1 | Software read of the capture register; clears the capture flag |
| ovr_clr | input | 1 | Clears the overcapture flag |
| cap_value | output | CNT_W | Captured count |
| cap_flag | output | 1 | Capture flag |
| ovr_flag | output | 1 | Overcapture flag |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach from the ports is a non-zero divider count at the moment the channel is disabled. Only that state shows whether the count really is cleared rather than frozen. The stimulus gets there by selecting divide-by-2 and sending one edge. It then drops the enable, sends more edges, re-enables, and expects no capture on the next edge and a capture on the one after. The filter boundary is reached by pulses held exactly N-1 and exactly N cycles. Every expected timestamp is derived from the drive time plus 2+N cycles.

// File: rtl/capchan_pkg.sv
// Package: shared types and helpers for the capture channel.
// Assumes select codes are small (a few bits) so 1<<code fits in 32 bits.
package capchan_pkg;

    typedef enum logic {
        POL_RISE = 1'b0,
        POL_FALL = 1'b1
    } cap_pol_e;

    // Threshold for a run counter: (1 << code) - 1, truncated by the caller.
    function automatic int unsigned code_to_last(input int unsigned code);
        return (32'd1 << code) - 32'd1;
    endfunction

endpackage

// File: rtl/capchan_sync.sv
// Multi-stage synchroniser for one asynchronous bit.
// Assumes the input toggles no faster than the filter needs to see it.
module capchan_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                // First stage samples the raw pin.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[gi] <= 1'b0;
                    else        chain[gi] <= d_async;
                end
            end else begin : g_next
                // Later stages resample the previous stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[gi] <= 1'b0;
                    else        chain[gi] <= chain[gi-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/capchan_filter.sv
// Level filter: output follows input only after N consecutive differing samples.
// N = 1 << sel, so code 0 is a plain one-cycle register.
module capchan_filter #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    input  logic             din,
    output logic             lvl
);
    import capchan_pkg::*;

    localparam int RUN_W = (1 << SEL_W) - 1;

    logic [RUN_W-1:0] run;
    logic [RUN_W-1:0] last;

    // Decode the sample count code into the final run value.
    always_comb begin
        last = RUN_W'(code_to_last(32'(sel)));
    end

    // Count differing samples and flip the level when the run completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl <= 1'b0;
            run <= '0;
        end else if (din == lvl) begin
            run <= '0;
        end else if (run == last) begin
            lvl <= din;
            run <= '0;
        end else begin
            run <= run + 1'b1;
        end
    end
endmodule

// File: rtl/capchan_qualify.sv
// Edge selection plus event divider; emits a one-cycle capture strobe.
// Assumes psc code is changed only when the divider count is below the new limit.
module capchan_qualify #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             pol,
    input  logic [SEL_W-1:0] psc,
    input  logic             lvl,
    output logic             fire
);
    import capchan_pkg::*;

    localparam int PCNT_W = (1 << SEL_W) - 1;

    logic              prev;
    logic              hit;
    logic [PCNT_W-1:0] pcnt;
    logic [PCNT_W-1:0] plast;

    // Remember the previous filtered level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= lvl;
    end

    // Pick the selected transition and decode the divider limit.
    always_comb begin
        if (cap_pol_e'(pol) == POL_FALL) hit = prev & ~lvl;
        else                             hit = lvl & ~prev;
        plast = PCNT_W'(code_to_last(32'(psc)));
    end

    // Count qualifying edges; cleared while the channel is off.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            pcnt <= '0;
        end else if (hit) begin
            if (pcnt == plast) pcnt <= '0;
            else               pcnt <= pcnt + 1'b1;
        end
    end

    assign fire = en & hit & (pcnt == plast);
endmodule

// File: rtl/capture_channel.sv
// Top: one input-capture channel with synchroniser, filter, edge/divider
// qualification, capture register and flags. The count bus comes from an
// external time base and is assumed synchronous to clk.
module capture_channel #(
    parameter int CNT_W  = 16,
    parameter int SYNC_N = 2,
    parameter int FSEL_W = 2,
    parameter int PSEL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_en,
    input  logic              edge_sel,
    input  logic [FSEL_W-1:0] filt_sel,
    input  logic [PSEL_W-1:0] psc_sel,
    input  logic              irq_en,
    input  logic              pin_in,
    input  logic [CNT_W-1:0]  count_in,
    input  logic              rd_strobe,
    input  logic              ovr_clr,
    output logic [CNT_W-1:0]  cap_value,
    output logic              cap_flag,
    output logic              ovr_flag,
    output logic              irq
);
    logic pin_s;
    logic pin_f;
    logic fire;

    capchan_sync #(.STAGES(SYNC_N)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(pin_in), .q_sync(pin_s)
    );

    capchan_filter #(.SEL_W(FSEL_W)) u_filt (
        .clk(clk), .rst_n(rst_n), .sel(filt_sel), .din(pin_s), .lvl(pin_f)
    );

    capchan_qualify #(.SEL_W(PSEL_W)) u_qual (
        .clk(clk), .rst_n(rst_n), .en(chan_en), .pol(edge_sel),
        .psc(psc_sel), .lvl(pin_f), .fire(fire)
    );

    // Latch the time-base count on each qualified event.
    always_ff @(posedge clk) begin
        if (!rst_n)    cap_value <= '0;
        else if (fire) cap_value <= count_in;
    end

    // Capture flag: set by capture, cleared by a read; capture wins.
    always_ff @(posedge clk) begin
        if (!rst_n)         cap_flag <= 1'b0;
        else if (fire)      cap_flag <= 1'b1;
        else if (rd_strobe) cap_flag <= 1'b0;
    end

    // Overcapture flag: an unread value was overwritten.
    always_ff @(posedge clk) begin
        if (!rst_n)                              ovr_flag <= 1'b0;
        else if (fire && cap_flag && !rd_strobe) ovr_flag <= 1'b1;
        else if (ovr_clr)                        ovr_flag <= 1'b0;
    end

    assign irq = cap_flag & irq_en;
endmodule

// File: rtl/capture_channel_checker.sv
// Checker for capture_channel; bound to every instance of the top.
module capture_channel_checker (
    input logic clk,
    input logic rst_n,
    input logic chan_en,
    input logic irq_en,
    input logic rd_strobe,
    input logic ovr_clr,
    input logic fire,
    input logic cap_flag,
    input logic ovr_flag,
    input logic irq
);
    // R6
    disabled_no_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |-> !fire);

    // R7
    flag_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> cap_flag);

    // R7
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !fire) |=> !cap_flag);

    // R8
    ovr_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && cap_flag && !rd_strobe) |=> ovr_flag);

    // R8
    ovr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_clr && !(fire && cap_flag)) |=> !ovr_flag);

    // R9
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (cap_flag && irq_en));
endmodule

bind capture_channel capture_channel_checker u_chk (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .irq_en(irq_en),
    .rd_strobe(rd_strobe), .ovr_clr(ovr_clr), .fire(fire),
    .cap_flag(cap_flag), .ovr_flag(ovr_flag), .irq(irq)
);

// File: tb/capture_channel_bench.sv
module capture_channel_bench;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             chan_en = 1'b0;
    logic             edge_sel = 1'b0;
    logic [1:0]       filt_sel = 2'd0;
    logic [1:0]       psc_sel = 2'd0;
    logic             irq_en = 1'b0;
    logic             pin_in = 1'b0;
    logic [CNT_W-1:0] count_in;
    logic             rd_strobe = 1'b0;
    logic             ovr_clr = 1'b0;
    logic [CNT_W-1:0] cap_value;
    logic             cap_flag;
    logic             ovr_flag;
    logic             irq;

    int total = 0;
    int bad = 0;
    bit done = 0;
    int unsigned tb_cnt = 0;
    int unsigned exp_q[$];
    int psc_ev = 0;
    logic [CNT_W-1:0] last_seen = '0;

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) tb_cnt <= 0;
        else        tb_cnt <= tb_cnt + 1;
    end
    assign count_in = CNT_W'(tb_cnt);

    capture_channel u_capture_channel (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .edge_sel(edge_sel),
        .filt_sel(filt_sel), .psc_sel(psc_sel), .irq_en(irq_en),
        .pin_in(pin_in), .count_in(count_in), .rd_strobe(rd_strobe),
        .ovr_clr(ovr_clr), .cap_value(cap_value), .cap_flag(cap_flag),
        .ovr_flag(ovr_flag), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int nsamp();
        return 1 << filt_sel;
    endfunction

    // Requirement model of edge selection and divider; pushes a timestamp.
    task automatic model_edge(input logic newv, input int unsigned c);
        bit hit;
        hit = (edge_sel == 1'b0) ? (newv == 1'b1) : (newv == 1'b0);
        if (chan_en && hit) begin
            psc_ev++;
            if (psc_ev == (1 << psc_sel)) begin
                psc_ev = 0;
                exp_q.push_back(c + 2 + nsamp());
            end
        end
    endtask

    // Driver: set a new stable pin level and predict the capture.
    task automatic drive_pin(input logic v);
        @(negedge clk);
        if (v != pin_in) model_edge(v, tb_cnt);
        pin_in = v;
        repeat (nsamp() + 6) @(negedge clk);
    endtask

    // Driver: pulse of given width; accepted only if width >= N (R4).
    task automatic pulse(input int width);
        int unsigned c0;
        int unsigned c1;
        logic v;
        @(negedge clk);
        v = ~pin_in;
        c0 = tb_cnt;
        pin_in = v;
        repeat (width) @(negedge clk);
        c1 = tb_cnt;
        pin_in = ~v;
        if (width >= nsamp()) begin
            model_edge(v, c0);
            model_edge(~v, c1);
        end
        repeat (nsamp() + 6) @(negedge clk);
    endtask

    task automatic do_read();
        @(negedge clk); rd_strobe = 1'b1;
        @(negedge clk); rd_strobe = 1'b0;
    endtask

    task automatic do_ovr_clr();
        @(negedge clk); ovr_clr = 1'b1;
        @(negedge clk); ovr_clr = 1'b0;
    endtask

    // Monitor: pop an expected timestamp on every change of the capture value.
    always @(negedge clk) begin
        if (!rst_n) begin
            last_seen <= '0;
        end else if (cap_value != last_seen) begin
            last_seen <= cap_value;
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL R2/R6 unexpected capture actual=%0d expected=none", cap_value);
            end else begin
                check("R2 capture timestamp", int'(cap_value), int'(CNT_W'(exp_q.pop_front())));
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [CNT_W-1:0] held;
        repeat (5) @(negedge clk);
        // R1 reset state
        check("R1 cap_value", int'(cap_value), 0);
        check("R1 cap_flag", int'(cap_flag), 0);
        check("R1 ovr_flag", int'(ovr_flag), 0);
        check("R1 irq", int'(irq), 0);
        rst_n = 1'b1;
        chan_en = 1'b1;
        irq_en = 1'b1;
        repeat (4) @(negedge clk);

        // R2, R7, R9: rising capture, flag, irq
        drive_pin(1'b1);
        check("R7 flag after capture", int'(cap_flag), 1);
        check("R9 irq with enable", int'(irq), 1);
        drive_pin(1'b0);
        do_read();
        check("R7 flag cleared by read", int'(cap_flag), 0);
        check("R9 irq low after read", int'(irq), 0);
        irq_en = 1'b0;
        drive_pin(1'b1);
        check("R9 irq masked", int'(irq), 0);
        check("R7 flag set while masked", int'(cap_flag), 1);
        do_read();
        irq_en = 1'b1;

        // R3: falling edges
        edge_sel = 1'b1;
        drive_pin(1'b0);
        drive_pin(1'b1);
        check("R3 flag after falling", int'(cap_flag), 1);
        do_read();
        drive_pin(1'b0);
        drive_pin(1'b1);
        drive_pin(1'b0);
        // R8 overcapture
        check("R8 ovr set", int'(ovr_flag), 1);
        do_ovr_clr();
        check("R8 ovr cleared", int'(ovr_flag), 0);
        do_read();
        drive_pin(1'b1);

        // R4: filter boundaries
        edge_sel = 1'b0;
        pin_in = 1'b0;
        repeat (20) @(negedge clk);
        exp_q.delete();
        last_seen = cap_value;
        filt_sel = 2'd2;
        held = cap_value;
        pulse(3);
        check("R4 short pulse ignored", int'(cap_value), int'(held));
        pulse(4);
        filt_sel = 2'd3;
        held = cap_value;
        pulse(7);
        check("R4 short pulse ignored N=8", int'(cap_value), int'(held));
        pulse(8);
        drive_pin(1'b1);
        drive_pin(1'b0);
        filt_sel = 2'd1;
        pulse(1);
        pulse(2);
        do_read();
        do_ovr_clr();

        // R5: divider settings
        filt_sel = 2'd0;
        psc_sel = 2'd2;
        for (int i = 0; i < 8; i++) begin
            drive_pin(1'b1);
            drive_pin(1'b0);
        end
        psc_sel = 2'd1;
        for (int i = 0; i < 3; i++) begin
            drive_pin(1'b1);
            drive_pin(1'b0);
        end
        psc_sel = 2'd3;
        for (int i = 0; i < 8; i++) begin
            drive_pin(1'b1);
            drive_pin(1'b0);
        end
        check("R5 divider queue drained", exp_q.size(), 0);

        // R6: disable clears divider and blocks captures
        psc_sel = 2'd1;
        psc_ev = 0;
        chan_en = 1'b0;
        repeat (3) @(negedge clk);
        chan_en = 1'b1;
        drive_pin(1'b1);
        drive_pin(1'b0);
        chan_en = 1'b0;
        psc_ev = 0;
        do_read();
        held = cap_value;
        for (int i = 0; i < 3; i++) begin
            drive_pin(1'b1);
            drive_pin(1'b0);
        end
        check("R6 no capture while off", int'(cap_value), int'(held));
        check("R6 no flag while off", int'(cap_flag), 0);
        chan_en = 1'b1;
        drive_pin(1'b1);
        drive_pin(1'b0);
        check("R6 divider restarted", int'(cap_value), int'(held));
        drive_pin(1'b1);
        drive_pin(1'b0);
        check("R6 capture after two edges", int'(cap_flag), 1);

        repeat (10) @(negedge clk);
        check("R2 all expected captures seen", exp_q.size(), 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule